// File: doc/BRIEF.md
# NAND Flash Identification and Reset Responder

This block is the device side of a parallel NAND flash command port, limited to two commands: product identification and reset. It watches chip enable, command latch, address latch, write strobe and read strobe, all synchronised to a system clock, and captures a byte from the input bus on each write-strobe rising edge while chip enable is low. It returns the identification bytes on the output bus during read strobes. It also drives an active-low ready/busy line and exposes an 8-bit status value.

An identification sequence is the command byte 90h followed by one address byte of 00h. The reads that follow return the maker code ECh, then a device code fixed by a parameter, then 00h. Command byte FFh starts a reset. The reset holds ready/busy low for a set number of clock cycles and cancels any busy operation in progress. A one-cycle `busy_start` pulse from outside stands in for such an operation, for example an array read, program or erase.

The state machine has five states:
- `ST_READ1`: idle, waiting for a command.
- `ST_ID_ADDR`: 90h seen, waiting for the address.
- `ST_ID_DATA`: identification reads.
- `ST_OP_BUSY`: modelled operation running.
- `ST_RESETTING`: reset in progress.

Transitions:
- `ST_READ1`, `ST_ID_ADDR` or `ST_ID_DATA` go to `ST_RESETTING` on FFh.
- The same three states go to `ST_ID_ADDR` on 90h.
- The same three states go to `ST_READ1` on any other command.
- `ST_READ1` or `ST_ID_DATA` go to `ST_OP_BUSY` on `busy_start`.
- `ST_ID_ADDR` goes to `ST_ID_DATA` on address 00h and to `ST_READ1` on any other address.
- `ST_OP_BUSY` goes to `ST_RESETTING` on FFh, or to `ST_READ1` when its timer expires.
- `ST_RESETTING` goes to `ST_READ1` when its timer expires and ignores every command meanwhile.

Top module: `nand_idrst_resp`

## Requirements
- R1: A bus cycle is captured only on a rising edge of `we_n` while `ce_n` is low; `cle` high with `ale` low marks a command, `ale` high with `cle` low marks an address; a cycle with `ce_n` high has no effect.
- R2: Command 90h followed by address 00h enters identification mode; any other address returns to idle with no identification output.
- R3: In identification mode, read cycles (each ended by a `re_n` rising edge) return ECh first, then `DEV_CODE` (one of 35h, 45h, 55h, 75h), then 00h for every later read.
- R4: `io_oe` is 1 only while `ce_n` and `re_n` are both low in identification mode; otherwise it is 0.
- R5: Identification mode lasts until another command is written; a new 90h/00h sequence restarts at the maker byte, and any other command ends the mode.
- R6: Command FFh drives `rb_n` low from the next clock edge for exactly `TRST` cycles, then high; status bit 6 equals `rb_n` at all times.
- R7: FFh written during a busy operation aborts it, so `rb_n` rises `TRST` cycles after the command and not when the operation would have ended.
- R8: FFh written while a reset is running is ignored and does not lengthen the reset.
- R9: Status bit 7 takes the value of `wp_n` when a reset is accepted and bits 5:0 read 0, so status reads C0h after reset with `wp_n` high and 40h with `wp_n` low; after power-up it reads C0h.
- R10: After reset the block is idle in read mode: identification mode is cleared and reads leave `io_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, byte captured on rising edge |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| busy_start | input | 1 | One-cycle pulse that starts a modelled busy operation |
| io_in | input | 8 | Byte driven onto the bus by the host |
| io_out | output | 8 | Byte driven by the device |
| io_oe | output | 1 | Output enable for `io_out` (0 means high impedance) |
| rb_n | output | 1 | Ready (1) / busy (0) |
| status | output | 8 | Status value: bit 7 write-protect, bit 6 ready |

## Verification
The assertions check four properties on every cycle:
- The output enable only comes on under a low chip enable and a low read strobe.
- Status bit 6 mirrors ready/busy.
- Every FFh command, whatever the state, pulls ready/busy low on the next edge.
- No accepted reset keeps ready/busy low for more than `TRST` cycles.

Only the bench's scenarios can show the following:
- The order of the identification bytes.
- Rejection of a wrong address or of a cycle with chip enable high.
- That identification mode persists and is cleared by reset.
- That a reset cuts a busy operation short.
- The exact reset length when a second FFh arrives.
- How the write-protect level lands in the status value.

// File: rtl/nand_idrst_pkg.sv
package nand_idrst_pkg;

    localparam logic [7:0] OPC_READ_ID  = 8'h90;
    localparam logic [7:0] OPC_RESET    = 8'hFF;
    localparam logic [7:0] ID_ADDR_BYTE = 8'h00;
    localparam logic [7:0] MAKER_BYTE   = 8'hEC;
    localparam logic [7:0] FILL_BYTE    = 8'h00;

    typedef enum logic [2:0] {
        ST_READ1     = 3'd0,
        ST_ID_ADDR   = 3'd1,
        ST_ID_DATA   = 3'd2,
        ST_OP_BUSY   = 3'd3,
        ST_RESETTING = 3'd4
    } st_e;

    typedef struct packed {
        logic cmd_stb;
        logic addr_stb;
        logic rd_done;
    } bus_ev_t;

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
    import nand_idrst_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ce_n,
    input  logic    cle,
    input  logic    ale,
    input  logic    we_n,
    input  logic    re_n,
    output bus_ev_t ev
);

    logic we_q;
    logic re_q;
    logic we_rise;
    logic re_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    assign we_rise = we_n && !we_q && !ce_n;
    assign re_rise = re_n && !re_q && !ce_n;

    always_comb begin
        ev.cmd_stb  = we_rise && cle && !ale;
        ev.addr_stb = we_rise && ale && !cle;
        ev.rd_done  = re_rise;
    end

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == W'(1)) && !load;

endmodule

// File: rtl/nand_idrst_resp.sv
module nand_idrst_resp
    import nand_idrst_pkg::*;
#(
    parameter logic [7:0] DEV_CODE  = 8'h75,
    parameter int         TRST      = 20,
    parameter int         BUSY_CYC  = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic       busy_start,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rb_n,
    output logic [7:0] status
);

    localparam int TMAX = (TRST > BUSY_CYC) ? TRST : BUSY_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    st_e          state_q;
    st_e          state_d;
    bus_ev_t      ev;
    logic         tmr_load;
    logic [TW-1:0] tmr_val;
    logic         tmr_expire;
    logic [1:0]   idx_q;
    logic         wp_bit_q;
    logic         is_reset_cmd;
    logic         is_id_cmd;
    logic         reset_accept;

    nand_bus_sampler u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .cle   (cle),
        .ale   (ale),
        .we_n  (we_n),
        .re_n  (re_n),
        .ev    (ev)
    );

    nand_busy_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    assign is_reset_cmd = ev.cmd_stb && (io_in == OPC_RESET);
    assign is_id_cmd    = ev.cmd_stb && (io_in == OPC_READ_ID);
    assign reset_accept = is_reset_cmd && (state_q != ST_RESETTING);

    // next-state logic
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_READ1, ST_ID_ADDR, ST_ID_DATA: begin
                if (is_reset_cmd) begin
                    state_d  = ST_RESETTING;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TRST);
                end else if (is_id_cmd) begin
                    state_d = ST_ID_ADDR;
                end else if (ev.cmd_stb) begin
                    state_d = ST_READ1;
                end else if (state_q == ST_ID_ADDR) begin
                    if (ev.addr_stb) begin
                        state_d = (io_in == ID_ADDR_BYTE) ? ST_ID_DATA : ST_READ1;
                    end
                end else if (busy_start) begin
                    state_d  = ST_OP_BUSY;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(BUSY_CYC);
                end
            end
            ST_OP_BUSY: begin
                if (is_reset_cmd) begin
                    state_d  = ST_RESETTING;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TRST);
                end else if (tmr_expire) begin
                    state_d = ST_READ1;
                end
            end
            ST_RESETTING: begin
                if (tmr_expire) begin
                    state_d = ST_READ1;
                end
            end
            default: state_d = ST_READ1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ1;
        end else begin
            state_q <= state_d;
        end
    end

    // identification byte pointer and write-protect latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= 2'd0;
            wp_bit_q <= 1'b1;
        end else begin
            if (state_d == ST_ID_DATA && state_q != ST_ID_DATA) begin
                idx_q <= 2'd0;
            end else if (state_q == ST_ID_DATA && ev.rd_done && idx_q != 2'd2) begin
                idx_q <= idx_q + 2'd1;
            end
            if (reset_accept) begin
                wp_bit_q <= wp_n;
            end
        end
    end

    // outputs
    always_comb begin
        rb_n   = !(state_q == ST_OP_BUSY || state_q == ST_RESETTING);
        status = {wp_bit_q, rb_n, 6'b000000};
        io_oe  = (state_q == ST_ID_DATA) && !ce_n && !re_n;
        unique case (idx_q)
            2'd0:    io_out = MAKER_BYTE;
            2'd1:    io_out = DEV_CODE;
            default: io_out = FILL_BYTE;
        endcase
    end

endmodule

// File: rtl/nand_idrst_sva.sv
module nand_idrst_sva
    import nand_idrst_pkg::*;
#(
    parameter logic [7:0] DEV_CODE = 8'h75,
    parameter int         TRST     = 20,
    parameter int         BUSY_CYC = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic [7:0] io_in,
    input logic       io_oe,
    input logic       rb_n,
    input logic [7:0] status,
    input st_e        state
);

    logic        we_seen;
    logic        rst_taken;
    logic [31:0] low_cnt;

    initial begin
        a_dev_code_r3: assert (DEV_CODE == 8'h35 || DEV_CODE == 8'h45 ||
                               DEV_CODE == 8'h55 || DEV_CODE == 8'h75)
            else $error("DEV_CODE outside the permitted set");
        a_timer_len_r6: assert (TRST >= 2 && BUSY_CYC >= 2)
            else $error("timer lengths must be at least 2");
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_seen <= 1'b1;
        end else begin
            we_seen <= we_n;
        end
    end

    assign rst_taken = we_n && !we_seen && !ce_n && cle && !ale &&
                       (io_in == 8'hFF) && (state != ST_RESETTING);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (rst_taken) begin
            low_cnt <= 32'd1;
        end else if (rb_n) begin
            low_cnt <= '0;
        end else if (low_cnt != '0) begin
            low_cnt <= low_cnt + 32'd1;
        end
    end

    p_oe_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> (!ce_n && !re_n));

    p_ready_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] == rb_n);

    p_reset_goes_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) && !ce_n && cle && !ale && io_in == 8'hFF) |=> !rb_n);

    p_reset_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_n && low_cnt != '0) |-> (low_cnt <= 32'(TRST)));

endmodule

bind nand_idrst_resp nand_idrst_sva #(
    .DEV_CODE (DEV_CODE),
    .TRST     (TRST),
    .BUSY_CYC (BUSY_CYC)
) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .cle    (cle),
    .ale    (ale),
    .we_n   (we_n),
    .re_n   (re_n),
    .io_in  (io_in),
    .io_oe  (io_oe),
    .rb_n   (rb_n),
    .status (status),
    .state  (state_q)
);

// File: tb/nand_idrst_resp_test.sv
`timescale 1ns/1ps
module nand_idrst_resp_test;

    localparam logic [7:0] DEV  = 8'h75;
    localparam int         TRST = 20;
    localparam int         BUSY = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b0;
    logic       cle = 1'b0;
    logic       ale = 1'b0;
    logic       we_n = 1'b1;
    logic       re_n = 1'b1;
    logic       wp_n = 1'b1;
    logic       busy_start = 1'b0;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic       io_oe;
    logic       rb_n;
    logic [7:0] status;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    nand_idrst_resp #(.DEV_CODE(DEV), .TRST(TRST), .BUSY_CYC(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .busy_start(busy_start),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n),
        .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic is_cmd, input logic [7:0] b);
        @(negedge clk);
        cle = is_cmd; ale = !is_cmd; io_in = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic bus_read(output logic oe, output logic [7:0] d);
        @(negedge clk);
        re_n = 1'b0;
        #1;
        oe = io_oe; d = io_out;
        @(negedge clk);
        re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rb_n && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_power_up;
        chk("R9 power-up status", status, 8'hC0);
        chk("R6 power-up rb_n", rb_n, 1);
        chk("R4 idle io_oe", io_oe, 0);
    endtask

    task automatic t_id_read;
        logic oe; logic [7:0] d;
        bus_write(1'b1, 8'h90);
        bus_write(1'b0, 8'h00);
        chk("R4 oe with re_n high", io_oe, 0);
        bus_read(oe, d); chk("R2 id mode oe", oe, 1); chk("R3 maker byte", d, 8'hEC);
        bus_read(oe, d); chk("R3 device byte", d, DEV);
        bus_read(oe, d); chk("R3 third byte", d, 8'h00);
        bus_read(oe, d); chk("R5 mode persists oe", oe, 1); chk("R3 fourth byte", d, 8'h00);
        @(negedge clk); ce_n = 1'b1; re_n = 1'b0; #1;
        chk("R4 oe with ce_n high", io_oe, 0);
        @(negedge clk); re_n = 1'b1; ce_n = 1'b0;
        bus_write(1'b1, 8'h90);
        bus_write(1'b0, 8'h00);
        bus_read(oe, d); chk("R5 restart at maker", d, 8'hEC);
        bus_write(1'b1, 8'h30);
        bus_read(oe, d); chk("R5 other command ends id", oe, 0);
    endtask

    task automatic t_bad_addr;
        logic oe; logic [7:0] d;
        bus_write(1'b1, 8'h90);
        bus_write(1'b0, 8'h01);
        bus_read(oe, d); chk("R2 wrong address no id", oe, 0);
    endtask

    task automatic t_ce_high;
        logic oe; logic [7:0] d;
        @(negedge clk); ce_n = 1'b1;
        bus_write(1'b1, 8'h90);
        @(negedge clk); ce_n = 1'b0;
        bus_write(1'b0, 8'h00);
        bus_read(oe, d); chk("R1 ce_n high cycle ignored", oe, 0);
        @(negedge clk); ce_n = 1'b1;
        bus_write(1'b1, 8'hFF);
        chk("R1 reset with ce_n high ignored", rb_n, 1);
        @(negedge clk); ce_n = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        bus_write(1'b1, 8'hFF);
        chk("R6 busy after reset cmd", rb_n, 0);
        chk("R9 status during reset", status, 8'h80);
        wait_ready(n);
        chk("R6 reset length", n, TRST);
        chk("R9 status after reset", status, 8'hC0);
    endtask

    task automatic t_abort;
        int n;
        @(negedge clk); busy_start = 1'b1;
        @(negedge clk); busy_start = 1'b0;
        chk("R7 busy op running", rb_n, 0);
        repeat (10) @(negedge clk);
        bus_write(1'b1, 8'hFF);
        wait_ready(n);
        chk("R7 aborted after TRST", n, TRST);
    endtask

    task automatic t_double_reset;
        int n;
        bus_write(1'b1, 8'hFF);
        bus_write(1'b1, 8'hFF);
        wait_ready(n);
        chk("R8 second FFh ignored", n + 3, TRST);
    endtask

    task automatic t_wp_low;
        int n;
        logic oe; logic [7:0] d;
        bus_write(1'b1, 8'h90);
        bus_write(1'b0, 8'h00);
        wp_n = 1'b0;
        bus_write(1'b1, 8'hFF);
        chk("R9 status during reset wp low", status, 8'h00);
        wait_ready(n);
        chk("R9 status after reset wp low", status, 8'h40);
        wp_n = 1'b1;
        bus_read(oe, d); chk("R10 id cleared by reset", oe, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_power_up();
        t_id_read();
        t_bad_addr();
        t_ce_high();
        t_reset();
        t_abort();
        t_double_reset();
        t_wp_low();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule